// File: doc/BRIEF.md
# Command/Status Indirect Register Bridge

This block lets a host reach a 32-bit internal register bus through a small window of 64-bit control and status registers. The host packs an opcode, a 13-bit register address and 32 bits of write data into a single 64-bit control word. The bridge turns that word into one request on the internal valid/ready bus, waits for the response and posts the outcome in a 64-bit status word. The host then polls that word until the completion flag is set.

A third, read-only word describes the serial master that sits behind the internal bus. It holds the shift order, transfer width, chip-select count, clock polarity and phase, and a 16-bit peripheral identifier. Its contents are fixed by module parameters at elaboration time. Only one transaction can be in flight. A command that arrives while another is pending is discarded, and a sticky flag records that it was lost.

Top module: `cmd_status_bridge`

## Requirements
- R1: After reset the status word reads as zero, the completion flag (status bit 32) and the lost-command flag (status bit 33) are clear, and no internal request is raised.
- R2: Offset 0x8 returns the parameter word. Bit 1 is the shift order (1 = LSB first). Bits 7:2 are the transfer width, bits 13:8 the chip-select count, bit 14 clock polarity, bit 15 clock phase and bits 47:32 the peripheral ID. Every other bit is zero.
- R3: A write to offset 0x10 with opcode bits 63:62 = 1 (read) or 2 (write) raises exactly one internal request. The request carries address bits 44:32 and data bits 31:0, marks write for opcode 2, and holds all of these steady until it is accepted by ready.
- R4: An accepted read or write command clears the completion flag (status bit 32) in the cycle after the control write. The flag is set again when the internal response arrives.
- R5: When a read completes, status bits 31:0 take the response data.
- R6: When a write completes, status bits 31:0 keep their previous value, whatever data the response carries.
- R7: Opcode 0 (no operation) and the unused opcode 3 raise no request and leave the status word unchanged.
- R8: A read or write command written while a transaction is pending raises no request and does not disturb the pending one. It sets status bit 33, which stays set until reset.
- R9: A host read returns data one cycle later, with csr_rd_valid high for that one cycle. Offset 0x18 returns status, offset 0x10 returns the last word written there, and any unmapped offset returns zero.
- R10: A response pulse from the internal bus when no transaction is waiting for one leaves the status word unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_wr_en | input | 1 | Host write strobe |
| csr_rd_en | input | 1 | Host read strobe |
| csr_addr | input | CSR_AW | Host byte offset |
| csr_wr_data | input | 64 | Host write data |
| csr_rd_data | output | 64 | Host read data, registered |
| csr_rd_valid | output | 1 | Read data valid, one cycle after csr_rd_en |
| rb_req_valid | output | 1 | Internal request valid |
| rb_req_ready | input | 1 | Internal request accepted |
| rb_req_write | output | 1 | 1 = write request, 0 = read request |
| rb_req_addr | output | 13 | Internal register address |
| rb_req_wdata | output | 32 | Internal write data |
| rb_rsp_valid | input | 1 | Internal response pulse |
| rb_rsp_rdata | input | 32 | Internal response data |

## Verification
The bench builds the bridge with LSB-first shifting, a transfer width of 32, three chip selects, clock phase 1, clock polarity 0 and peripheral ID 0xA5C3. This asymmetric set of values shows whether any field of the parameter word is misplaced or swapped. The register-bus model in the bench can delay both ready and the response by a chosen number of cycles. A long ready delay holds a transaction pending, which makes the cleared completion flag visible and lets a second command collide with the first. The model also returns nonzero data on writes and can inject stray response pulses, so the cases where status must stay unchanged are exercised.

// File: rtl/cmdbr_pkg.sv
package cmdbr_pkg;

  // host-side byte offsets of the three 64-bit words
  localparam logic [7:0] OFS_PARAM = 8'h08;
  localparam logic [7:0] OFS_CTRL  = 8'h10;
  localparam logic [7:0] OFS_STAT  = 8'h18;

  localparam int CSR_DW = 64;
  localparam int RB_AW  = 13;
  localparam int RB_DW  = 32;

  // control word field positions
  localparam int CTRL_ADDR_LSB = 32;
  localparam int CTRL_OP_LSB   = 62;

  // status word flag positions
  localparam int STAT_DONE_BIT = 32;
  localparam int STAT_LOST_BIT = 33;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2,
    OP_RSVD  = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } eng_st_e;

endpackage

// File: rtl/cmdbr_param_word.sv
module cmdbr_param_word #(
  parameter bit          SHIFT_LSB_FIRST = 1'b0,
  parameter int          XFER_WIDTH      = 32,
  parameter int          CS_COUNT        = 1,
  parameter bit          CLK_POL         = 1'b0,
  parameter bit          CLK_PHA         = 1'b0,
  parameter logic [15:0] PERIPH_ID       = 16'h0000
) (
  output logic [63:0] param_word
);
  localparam logic [5:0] WIDTH_F = 6'(XFER_WIDTH);
  localparam logic [5:0] CS_F    = 6'(CS_COUNT);

  // 16 + 16 + 16 + 1 + 1 + 6 + 6 + 1 + 1 = 64 bits
  assign param_word = {16'h0000, PERIPH_ID, 16'h0000, CLK_PHA, CLK_POL,
                       CS_F, WIDTH_F, SHIFT_LSB_FIRST, 1'b0};
endmodule

// File: rtl/cmdbr_host_port.sv
module cmdbr_host_port
  import cmdbr_pkg::*;
#(
  parameter int CSR_AW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csr_wr_en,
  input  logic              csr_rd_en,
  input  logic [CSR_AW-1:0] csr_addr,
  input  logic [CSR_DW-1:0] csr_wr_data,
  output logic [CSR_DW-1:0] csr_rd_data,
  output logic              csr_rd_valid,
  input  logic [CSR_DW-1:0] param_word,
  input  logic [CSR_DW-1:0] status_word,
  output logic              cmd_strobe,
  output op_e               cmd_op,
  output logic [RB_AW-1:0]  cmd_addr,
  output logic [RB_DW-1:0]  cmd_data
);
  logic              hit_param, hit_ctrl, hit_stat;
  logic [CSR_DW-1:0] ctrl_shadow;

  assign hit_param = (csr_addr == CSR_AW'(OFS_PARAM));
  assign hit_ctrl  = (csr_addr == CSR_AW'(OFS_CTRL));
  assign hit_stat  = (csr_addr == CSR_AW'(OFS_STAT));

  assign cmd_strobe = csr_wr_en && hit_ctrl;
  assign cmd_op     = op_e'(csr_wr_data[CTRL_OP_LSB +: 2]);
  assign cmd_addr   = csr_wr_data[CTRL_ADDR_LSB +: RB_AW];
  assign cmd_data   = csr_wr_data[RB_DW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_shadow <= '0;
    end else if (cmd_strobe) begin
      ctrl_shadow <= csr_wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      csr_rd_valid <= 1'b0;
      csr_rd_data  <= '0;
    end else begin
      csr_rd_valid <= csr_rd_en;
      if (csr_rd_en) begin
        if (hit_param)     csr_rd_data <= param_word;
        else if (hit_ctrl) csr_rd_data <= ctrl_shadow;
        else if (hit_stat) csr_rd_data <= status_word;
        else               csr_rd_data <= '0;
      end
    end
  end

  // R9: one-cycle read latency, valid exactly for one cycle per strobe
  assert_rd_latency_R9: assert property (@(posedge clk) disable iff (rst)
    csr_rd_en |=> csr_rd_valid);
  assert_rd_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !csr_rd_en |=> !csr_rd_valid);

endmodule

// File: rtl/cmdbr_txn_engine.sv
module cmdbr_txn_engine
  import cmdbr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_strobe,
  input  op_e               cmd_op,
  input  logic [RB_AW-1:0]  cmd_addr,
  input  logic [RB_DW-1:0]  cmd_data,
  output logic              rb_req_valid,
  input  logic              rb_req_ready,
  output logic              rb_req_write,
  output logic [RB_AW-1:0]  rb_req_addr,
  output logic [RB_DW-1:0]  rb_req_wdata,
  input  logic              rb_rsp_valid,
  input  logic [RB_DW-1:0]  rb_rsp_rdata,
  output logic [CSR_DW-1:0] status_word
);
  eng_st_e          st_q;
  logic             launch;
  logic             done_q;
  logic             lost_q;
  logic [RB_DW-1:0] rdata_q;

  assign launch = cmd_strobe && (cmd_op == OP_READ || cmd_op == OP_WRITE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q         <= ST_IDLE;
      rb_req_valid <= 1'b0;
      rb_req_write <= 1'b0;
      rb_req_addr  <= '0;
      rb_req_wdata <= '0;
      done_q       <= 1'b0;
      rdata_q      <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (launch) begin
            st_q         <= ST_REQ;
            rb_req_valid <= 1'b1;
            rb_req_write <= (cmd_op == OP_WRITE);
            rb_req_addr  <= cmd_addr;
            rb_req_wdata <= cmd_data;
            done_q       <= 1'b0;
          end
        end
        ST_REQ: begin
          if (rb_req_ready) begin
            rb_req_valid <= 1'b0;
            st_q         <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (rb_rsp_valid) begin
            done_q <= 1'b1;
            if (!rb_req_write) rdata_q <= rb_rsp_rdata;
            st_q <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // lost-command flag: sticky until reset
  always_ff @(posedge clk) begin
    if (rst)                          lost_q <= 1'b0;
    else if (launch && st_q != ST_IDLE) lost_q <= 1'b1;
  end

  always_comb begin
    status_word = '0;
    status_word[RB_DW-1:0]     = rdata_q;
    status_word[STAT_DONE_BIT] = done_q;
    status_word[STAT_LOST_BIT] = lost_q;
  end

  assert_req_hold_R3: assert property (@(posedge clk) disable iff (rst)
    rb_req_valid && !rb_req_ready |=> rb_req_valid && $stable(rb_req_addr)
      && $stable(rb_req_wdata) && $stable(rb_req_write));

  assert_issue_clears_done_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(rb_req_valid) |-> !status_word[STAT_DONE_BIT]);

  assert_wr_keeps_rdata_R6: assert property (@(posedge clk) disable iff (rst)
    st_q == ST_WAIT && rb_rsp_valid && rb_req_write |=> $stable(status_word[RB_DW-1:0]));

  assert_drop_keeps_req_R8: assert property (@(posedge clk) disable iff (rst)
    launch && st_q != ST_IDLE |=> $stable(rb_req_addr) && $stable(rb_req_write)
      && $stable(rb_req_wdata));

  assert_lost_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    status_word[STAT_LOST_BIT] |=> status_word[STAT_LOST_BIT]);

  assert_stray_rsp_R10: assert property (@(posedge clk) disable iff (rst)
    rb_rsp_valid && (st_q == ST_REQ || (st_q == ST_IDLE && !launch))
      |=> $stable(status_word[STAT_DONE_BIT:0]));

endmodule

// File: rtl/cmd_status_bridge.sv
module cmd_status_bridge
  import cmdbr_pkg::*;
#(
  parameter int          CSR_AW          = 8,
  parameter bit          SHIFT_LSB_FIRST = 1'b0,
  parameter int          XFER_WIDTH      = 32,
  parameter int          CS_COUNT        = 1,
  parameter bit          CLK_POL         = 1'b0,
  parameter bit          CLK_PHA         = 1'b0,
  parameter logic [15:0] PERIPH_ID       = 16'h0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csr_wr_en,
  input  logic              csr_rd_en,
  input  logic [CSR_AW-1:0] csr_addr,
  input  logic [63:0]       csr_wr_data,
  output logic [63:0]       csr_rd_data,
  output logic              csr_rd_valid,
  output logic              rb_req_valid,
  input  logic              rb_req_ready,
  output logic              rb_req_write,
  output logic [12:0]       rb_req_addr,
  output logic [31:0]       rb_req_wdata,
  input  logic              rb_rsp_valid,
  input  logic [31:0]       rb_rsp_rdata
);
  logic [CSR_DW-1:0] param_word;
  logic [CSR_DW-1:0] status_word;
  logic              cmd_strobe;
  op_e               cmd_op;
  logic [RB_AW-1:0]  cmd_addr;
  logic [RB_DW-1:0]  cmd_data;

  cmdbr_param_word #(
    .SHIFT_LSB_FIRST(SHIFT_LSB_FIRST),
    .XFER_WIDTH     (XFER_WIDTH),
    .CS_COUNT       (CS_COUNT),
    .CLK_POL        (CLK_POL),
    .CLK_PHA        (CLK_PHA),
    .PERIPH_ID      (PERIPH_ID)
  ) u_param (
    .param_word(param_word)
  );

  cmdbr_host_port #(.CSR_AW(CSR_AW)) u_host (
    .clk         (clk),
    .rst         (rst),
    .csr_wr_en   (csr_wr_en),
    .csr_rd_en   (csr_rd_en),
    .csr_addr    (csr_addr),
    .csr_wr_data (csr_wr_data),
    .csr_rd_data (csr_rd_data),
    .csr_rd_valid(csr_rd_valid),
    .param_word  (param_word),
    .status_word (status_word),
    .cmd_strobe  (cmd_strobe),
    .cmd_op      (cmd_op),
    .cmd_addr    (cmd_addr),
    .cmd_data    (cmd_data)
  );

  cmdbr_txn_engine u_eng (
    .clk         (clk),
    .rst         (rst),
    .cmd_strobe  (cmd_strobe),
    .cmd_op      (cmd_op),
    .cmd_addr    (cmd_addr),
    .cmd_data    (cmd_data),
    .rb_req_valid(rb_req_valid),
    .rb_req_ready(rb_req_ready),
    .rb_req_write(rb_req_write),
    .rb_req_addr (rb_req_addr),
    .rb_req_wdata(rb_req_wdata),
    .rb_rsp_valid(rb_rsp_valid),
    .rb_rsp_rdata(rb_rsp_rdata),
    .status_word (status_word)
  );

  assert_no_req_in_reset_R1: assert property (@(posedge clk)
    rst |=> !rb_req_valid && !status_word[33] && !status_word[32]);

endmodule

// File: tb/test_cmd_status_bridge.sv
`timescale 1ns/1ps
module test_cmd_status_bridge;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        csr_wr_en = 1'b0;
  logic        csr_rd_en = 1'b0;
  logic [7:0]  csr_addr = '0;
  logic [63:0] csr_wr_data = '0;
  logic [63:0] csr_rd_data;
  logic        csr_rd_valid;
  logic        rb_req_valid, rb_req_write;
  logic [12:0] rb_req_addr;
  logic [31:0] rb_req_wdata;
  logic        rb_req_ready;
  logic        rb_rsp_valid;
  logic [31:0] rb_rsp_rdata;

  // bus model state
  logic        slv_ready = 1'b0, slv_rsp = 1'b0;
  logic [31:0] slv_rdata = '0;
  logic        stray_on = 1'b0;
  logic [31:0] stray_rdata = '0;
  int          ready_dly = 0, rsp_dly = 0;
  int          s_st = 0, s_cnt = 0;
  int          txn_cnt = 0;
  logic [12:0] cap_addr = '0;
  logic [31:0] cap_data = '0;
  logic        cap_write = 1'b0;
  logic [31:0] mem [16];

  int checks = 0, fails = 0;
  bit done_flag = 0;

  assign rb_req_ready = slv_ready;
  assign rb_rsp_valid = slv_rsp | stray_on;
  assign rb_rsp_rdata = stray_on ? stray_rdata : slv_rdata;

  always #2.5 clk = ~clk;

  cmd_status_bridge #(
    .CSR_AW(8), .SHIFT_LSB_FIRST(1'b1), .XFER_WIDTH(32), .CS_COUNT(3),
    .CLK_POL(1'b0), .CLK_PHA(1'b1), .PERIPH_ID(16'hA5C3)
  ) i_cmd_status_bridge (
    .clk(clk), .rst(rst), .csr_wr_en(csr_wr_en), .csr_rd_en(csr_rd_en),
    .csr_addr(csr_addr), .csr_wr_data(csr_wr_data), .csr_rd_data(csr_rd_data),
    .csr_rd_valid(csr_rd_valid), .rb_req_valid(rb_req_valid),
    .rb_req_ready(rb_req_ready), .rb_req_write(rb_req_write),
    .rb_req_addr(rb_req_addr), .rb_req_wdata(rb_req_wdata),
    .rb_rsp_valid(rb_rsp_valid), .rb_rsp_rdata(rb_rsp_rdata)
  );

  // register-bus model, updated away from the active edge
  always @(negedge clk) begin
    if (rst) begin
      s_st = 0; s_cnt = 0; slv_ready = 1'b0; slv_rsp = 1'b0;
    end else begin
      case (s_st)
        0: if (rb_req_valid) begin
             if (s_cnt >= ready_dly) begin
               slv_ready = 1'b1;
               cap_addr = rb_req_addr; cap_data = rb_req_wdata; cap_write = rb_req_write;
               txn_cnt++;
               if (rb_req_write) begin
                 mem[rb_req_addr[5:2]] = rb_req_wdata;
                 slv_rdata = 32'hFFFF_FFFF;
               end else begin
                 slv_rdata = mem[rb_req_addr[5:2]];
               end
               s_st = 1; s_cnt = 0;
             end else s_cnt++;
           end
        1: begin
             slv_ready = 1'b0;
             if (s_cnt >= rsp_dly) begin slv_rsp = 1'b1; s_st = 2; end
             else s_cnt++;
           end
        default: begin slv_rsp = 1'b0; s_st = 0; s_cnt = 0; end
      endcase
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [7:0] a, input logic [63:0] d);
    @(negedge clk);
    csr_wr_en = 1'b1; csr_addr = a; csr_wr_data = d;
    @(negedge clk);
    csr_wr_en = 1'b0;
  endtask

  task automatic host_read(input logic [7:0] a, output logic [63:0] d);
    @(negedge clk);
    csr_rd_en = 1'b1; csr_addr = a;
    @(negedge clk);
    csr_rd_en = 1'b0;
    d = csr_rd_data;
    check(csr_rd_valid === 1'b1, "R9 rd_valid", {63'd0, csr_rd_valid}, 64'd1);
  endtask

  function automatic logic [63:0] ctrl(input logic [1:0] op, input logic [12:0] a,
                                       input logic [31:0] d);
    return {op, 17'd0, a, d};
  endfunction

  task automatic poll_done(output logic [63:0] st);
    st = '0;
    for (int i = 0; i < 60; i++) begin
      host_read(8'h18, st);
      if (st[32]) break;
    end
  endtask

  task automatic t_reset();
    logic [63:0] v;
    check(rb_req_valid === 1'b0, "R1 no request", {63'd0, rb_req_valid}, 64'd0);
    host_read(8'h18, v);
    check(v === 64'd0, "R1 status reset", v, 64'd0);
    host_read(8'h20, v);
    check(v === 64'd0, "R9 unmapped offset", v, 64'd0);
  endtask

  task automatic t_param();
    logic [63:0] v, e;
    e = '0; e[1] = 1'b1; e[7:2] = 6'd32; e[13:8] = 6'd3; e[14] = 1'b0;
    e[15] = 1'b1; e[47:32] = 16'hA5C3;
    host_read(8'h08, v);
    check(v === e, "R2 parameter word", v, e);
  endtask

  task automatic t_write_then_read();
    logic [63:0] v, c;
    ready_dly = 0; rsp_dly = 1;
    c = ctrl(2'd2, 13'h010, 32'hDEAD_BEEF);
    host_write(8'h10, c);
    poll_done(v);
    check(cap_write === 1'b1 && cap_addr === 13'h010 && cap_data === 32'hDEAD_BEEF,
          "R3 write request fields", {18'd0, cap_write, cap_addr, cap_data},
          {18'd0, 1'b1, 13'h010, 32'hDEAD_BEEF});
    check(v[31:0] === 32'd0, "R6 write keeps rdata (reset value)", v, 64'h1_0000_0000);
    host_read(8'h10, v);
    check(v === c, "R9 control readback", v, c);
    host_write(8'h10, ctrl(2'd1, 13'h010, 32'h0));
    poll_done(v);
    check(cap_write === 1'b0 && cap_addr === 13'h010, "R3 read request fields",
          {50'd0, cap_write, cap_addr}, {50'd0, 1'b0, 13'h010});
    check(v[32] === 1'b1, "R4 done set after response", v, 64'h1_DEAD_BEEF);
    check(v[31:0] === 32'hDEAD_BEEF, "R5 read data", v, 64'h1_DEAD_BEEF);
  endtask

  task automatic t_write_keeps();
    logic [63:0] v;
    ready_dly = 2; rsp_dly = 0;
    host_write(8'h10, ctrl(2'd2, 13'h014, 32'h1234_5678));
    poll_done(v);
    check(v === 64'h1_DEAD_BEEF, "R6 write leaves rdata", v, 64'h1_DEAD_BEEF);
  endtask

  task automatic t_clear_on_issue();
    logic [63:0] v;
    ready_dly = 4; rsp_dly = 2;
    host_write(8'h10, ctrl(2'd1, 13'h014, 32'h0));
    host_read(8'h18, v);
    check(v[32] === 1'b0, "R4 done cleared on issue", v, {31'd0, 1'b0, v[31:0]});
    poll_done(v);
    check(v === 64'h1_1234_5678, "R5 read after delayed ready", v, 64'h1_1234_5678);
  endtask

  task automatic t_nop();
    logic [63:0] v;
    int n0;
    n0 = txn_cnt;
    host_write(8'h10, ctrl(2'd0, 13'h018, 32'hAAAA_0000));
    host_write(8'h10, ctrl(2'd3, 13'h018, 32'hBBBB_0000));
    repeat (8) @(negedge clk);
    check(txn_cnt == n0, "R7 no request for opcode 0/3", 64'(txn_cnt), 64'(n0));
    host_read(8'h18, v);
    check(v === 64'h1_1234_5678, "R7 status unchanged", v, 64'h1_1234_5678);
  endtask

  task automatic t_stray();
    logic [63:0] v;
    @(negedge clk);
    stray_rdata = 32'hBAD0_BAD0; stray_on = 1'b1;
    @(negedge clk);
    stray_on = 1'b0;
    repeat (2) @(negedge clk);
    host_read(8'h18, v);
    check(v === 64'h1_1234_5678, "R10 stray response ignored", v, 64'h1_1234_5678);
  endtask

  task automatic t_overflow();
    logic [63:0] v;
    int n0;
    host_read(8'h18, v);
    check(v[33] === 1'b0, "R8 lost flag clear before", v, {30'd0, 1'b0, v[32:0]});
    n0 = txn_cnt;
    ready_dly = 6; rsp_dly = 1;
    host_write(8'h10, ctrl(2'd2, 13'h018, 32'h0000_1111));
    host_write(8'h10, ctrl(2'd1, 13'h01C, 32'h0));
    poll_done(v);
    repeat (10) @(negedge clk);
    check(txn_cnt == n0 + 1, "R8 second command dropped", 64'(txn_cnt), 64'(n0 + 1));
    check(cap_addr === 13'h018 && cap_write === 1'b1 && cap_data === 32'h1111,
          "R8 pending transaction intact", {18'd0, cap_write, cap_addr, cap_data},
          {18'd0, 1'b1, 13'h018, 32'h1111});
    host_read(8'h18, v);
    check(v === 64'h3_1234_5678, "R8 lost flag set", v, 64'h3_1234_5678);
    ready_dly = 0; rsp_dly = 0;
    host_write(8'h10, ctrl(2'd1, 13'h018, 32'h0));
    poll_done(v);
    check(v === 64'h3_0000_1111, "R8 lost flag sticky", v, 64'h3_0000_1111);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 32'h0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_param();
    t_write_then_read();
    t_write_keeps();
    t_clear_on_issue();
    t_nop();
    t_stray();
    t_overflow();
    if (!done_flag) begin
      done_flag = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule